// File: doc/BRIEF.md
# Conditional Microprogram Sequencer

This block chooses the address of the next microword for a microprogrammed controller. The current microword sits in a pipeline register. Its next-address fields pick one of four modes: fall through to the following address, jump always, jump when a tested condition is true, or jump when it is false. The tested condition comes from a sixteen-way multiplexer. Slot 0 of that multiplexer is a constant true. Slots 1 to 4 hold datapath flags, which are latched one cycle late. Slots 5 to 15 take external status lines, which are sampled in the same cycle.

The chosen address leaves the block on `uaddr_o` and goes to an external control store. The control store returns the word at that address on `cs_word_i`, and this word is loaded into the pipeline register at the next clock edge. A handshake wait needs no separate stall input. A conditional microword branches to its own address, so it runs again until the awaited line (for example a bus-grant ready) changes. Control then passes to the following address.

The controller has two named states. `S_RST` is entered on every clock edge that sees the synchronous reset. In this state the fetch address is forced to 0 and the pipeline holds an all-zero no-op word. The transition `S_RST -> S_RUN` happens on the first edge without reset, and on that edge the word at address 0 is loaded. The transition `S_RUN -> S_RUN` happens on every later edge, and the fetch address follows the decoded mode. The transition `any -> S_RST` happens on an edge with reset asserted.

Top module: `useq_core`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `uaddr_o` is 0. In the cycle after an edge with reset asserted, `ctrl_o` is 0.
- R2: Mode code 00 (continue) makes the next address the current address plus one. The count wraps from 63 to 0.
- R3: Mode code 01 (jump) makes the next address the target field, whatever the condition.
- R4: Mode code 10 gives the target when the selected condition is 1, and the current address plus one otherwise.
- R5: Mode code 11 gives the target when the selected condition is 0, and the current address plus one otherwise.
- R6: Condition select code 0 always reads as true. Mode 10 with code 0 therefore always jumps, and mode 11 with code 0 never does.
- R7: Select codes 1 to 4 test `alu_flags_i[code-1]` as it was at the previous clock edge. Codes 5 to 15 test `ext_cond_i[code-5]` in the current cycle.
- R8: On every edge without reset, the pipeline loads `cs_word_i`. In the following cycle, `ctrl_o` shows bits [19:12] of that word. The word layout is: target in [5:0], condition select in [9:6], mode in [11:10], control in [19:12].
- R9: A conditional word whose target is its own address runs again while its branch is taken, and `wait_o` is 1 during that time. Once the branch is not taken, the next address is the word's address plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_word_i | input | 20 | Control store word at `uaddr_o` |
| alu_flags_i | input | 4 | Datapath flags; latched before they are tested |
| ext_cond_i | input | 11 | External status lines, condition codes 5..15 |
| uaddr_o | output | 6 | Address of the next microword to fetch |
| ctrl_o | output | 8 | Control field of the executing microword |
| wait_o | output | 1 | High while the executing word branches to itself |

## Verification
A small microprogram runs from a model of the control store. The program covers every mode, a self-loop wait on external line 0, flag tests, constant-true selects and a path that wraps through address 63. All conditions are first held at 0 and then at 1. In these two runs each conditional word always goes one way, which separates the taken path from the fall-through path and separates polarity from select errors. A long run with random flags and external lines follows. It shows whether the flags are tested with a one-cycle lag or without it, and whether the right slot is selected. A reset in the middle of the run shows that execution restarts from address 0.

// File: rtl/useq_pkg.sv
package useq_pkg;
    parameter int AW    = 6;
    parameter int CTRLW = 8;
    parameter int NFLAG = 4;
    parameter int NEXT  = 11;
    localparam int NCOND = 1 + NFLAG + NEXT;
    localparam int SELW  = $clog2(NCOND);
    localparam int WORDW = CTRLW + 2 + SELW + AW;

    typedef enum logic [1:0] {
        M_CONT = 2'b00,
        M_JUMP = 2'b01,
        M_JT   = 2'b10,
        M_JF   = 2'b11
    } nxt_mode_e;

    typedef struct packed {
        logic [CTRLW-1:0] ctrl;
        nxt_mode_e        mode;
        logic [SELW-1:0]  csel;
        logic [AW-1:0]    target;
    } uword_t;

    typedef enum logic {
        S_RST = 1'b0,
        S_RUN = 1'b1
    } seq_state_e;
endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] flags_i,
    input  logic [NEXT-1:0]  ext_i,
    input  logic [SELW-1:0]  csel_i,
    output logic             cond_o
);
    logic [NFLAG-1:0] flags_q;
    logic [NCOND-1:0] cond_vec;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_i;
    end

    assign cond_vec[0] = 1'b1;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        assign cond_vec[1+g] = flags_q[g];
    end

    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        assign cond_vec[1+NFLAG+g] = ext_i[g];
    end

    assign cond_o = cond_vec[csel_i];

    // R6: select code 0 reads as true
    p_const_true_r6: assert property (@(posedge clk) disable iff (rst)
        (csel_i == '0) |-> cond_o);

    // R7: flag slot 1 reflects the flag input of the previous edge
    p_flag_lag_r7: assert property (@(posedge clk) disable iff (rst)
        (csel_i == SELW'(1) && !$past(rst)) |-> (cond_o == $past(flags_i[0])));

    // R7: first external slot follows its input in the same cycle
    p_ext_now_r7: assert property (@(posedge clk) disable iff (rst)
        (csel_i == SELW'(NFLAG+1)) |-> (cond_o == ext_i[0]));
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  uword_t        word_i,
    input  logic [AW-1:0] pc_i,
    input  logic          cond_i,
    output logic          take_o,
    output logic [AW-1:0] naddr_o
);
    logic [AW-1:0] inc_addr;

    assign inc_addr = AW'(pc_i + 1'b1);

    always_comb begin
        unique case (word_i.mode)
            M_CONT: take_o = 1'b0;
            M_JUMP: take_o = 1'b1;
            M_JT:   take_o = cond_i;
            M_JF:   take_o = !cond_i;
        endcase
    end

    assign naddr_o = take_o ? word_i.target : inc_addr;

    // R3: jump mode always takes the branch
    p_jump_taken_r3: assert property (@(posedge clk) disable iff (rst)
        (word_i.mode == M_JUMP) |-> (naddr_o == word_i.target));

    // R2: continue mode never takes the branch
    p_cont_falls_r2: assert property (@(posedge clk) disable iff (rst)
        (word_i.mode == M_CONT) |-> !take_o);
endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [19:0]      cs_word_i,
    input  logic [3:0]       alu_flags_i,
    input  logic [10:0]      ext_cond_i,
    output logic [5:0]       uaddr_o,
    output logic [7:0]       ctrl_o,
    output logic             wait_o
);
    seq_state_e    state_q;
    logic [AW-1:0] pc_q;
    uword_t        mw_q;
    logic          cond;
    logic          take;
    logic [AW-1:0] naddr;
    logic [AW-1:0] fetch_addr;

    useq_cond_mux u_cmux (
        .clk     (clk),
        .rst     (rst),
        .flags_i (alu_flags_i),
        .ext_i   (ext_cond_i),
        .csel_i  (mw_q.csel),
        .cond_o  (cond)
    );

    useq_next_addr u_nxt (
        .clk     (clk),
        .rst     (rst),
        .word_i  (mw_q),
        .pc_i    (pc_q),
        .cond_i  (cond),
        .take_o  (take),
        .naddr_o (naddr)
    );

    // state register, program counter and pipeline register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_RST;
            pc_q    <= '0;
            mw_q    <= '0;
        end else begin
            state_q <= S_RUN;
            pc_q    <= fetch_addr;
            mw_q    <= uword_t'(cs_word_i);
        end
    end

    // outputs
    always_comb begin
        fetch_addr = '0;
        wait_o     = 1'b0;
        unique case (state_q)
            S_RST: begin
                fetch_addr = '0;
                wait_o     = 1'b0;
            end
            S_RUN: begin
                fetch_addr = naddr;
                wait_o     = take && (mw_q.target == pc_q);
            end
        endcase
        if (rst) begin
            fetch_addr = '0;
            wait_o     = 1'b0;
        end
    end

    assign uaddr_o = fetch_addr;
    assign ctrl_o  = mw_q.ctrl;

    // R1: the cycle after a reset edge fetches address 0 with a no-op in the pipe
    p_reset_fetch_r1: assert property (@(posedge clk)
        rst |=> (uaddr_o == '0 && ctrl_o == '0));

    // R2: a not-taken word advances the counter by one
    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RUN && !take) |=> (pc_q == AW'($past(pc_q) + 1'b1)));

    // R4: a taken branch lands on the target of the previous word
    p_branch_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RUN && take) |=> (pc_q == $past(mw_q.target)));

    // R8: the control field shows the word loaded at the last edge
    p_pipe_load_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ctrl_o == $past(cs_word_i[WORDW-1 -: CTRLW])));

    // R9: while waiting the address stays put
    p_wait_hold_r9: assert property (@(posedge clk) disable iff (rst)
        wait_o |-> (uaddr_o == pc_q));
endmodule

// File: tb/useq_core_bench.sv
module useq_core_bench;
    import useq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [WORDW-1:0]  cs_word_i;
    logic [NFLAG-1:0]  alu_flags_i = '0;
    logic [NEXT-1:0]   ext_cond_i = '0;
    logic [AW-1:0]     uaddr_o;
    logic [CTRLW-1:0]  ctrl_o;
    logic              wait_o;

    always #10 clk = ~clk;

    useq_core u_useq_core (
        .clk         (clk),
        .rst         (rst),
        .cs_word_i   (cs_word_i),
        .alu_flags_i (alu_flags_i),
        .ext_cond_i  (ext_cond_i),
        .uaddr_o     (uaddr_o),
        .ctrl_o      (ctrl_o),
        .wait_o      (wait_o)
    );

    uword_t rom [2**AW];
    assign cs_word_i = rom[uaddr_o];

    typedef struct {
        logic [AW-1:0]    addr;
        logic [CTRLW-1:0] ctrl;
        logic             wt;
        string            tag;
    } exp_t;
    exp_t q[$];

    int nvec = 0;
    int nbad = 0;

    logic [AW-1:0]    m_pc;
    uword_t           m_word;
    logic [NFLAG-1:0] m_flq;

    function automatic uword_t mk(int ctrl, nxt_mode_e md, int sel, int tgt);
        uword_t w;
        w.ctrl   = CTRLW'(ctrl);
        w.mode   = md;
        w.csel   = SELW'(sel);
        w.target = AW'(tgt);
        return w;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic cond_of(logic [SELW-1:0] sel, logic [NFLAG-1:0] flq,
                                     logic [NEXT-1:0] ext);
        if (sel == 0) return 1'b1;
        if (sel <= NFLAG) return flq[sel-1];
        return ext[sel-1-NFLAG];
    endfunction

    // monitor: pops an expected item after each push and compares
    always @(negedge clk) begin
        #4;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(uaddr_o == e.addr, e.tag, int'(uaddr_o), int'(e.addr));
            check(ctrl_o == e.ctrl, "R8", int'(ctrl_o), int'(e.ctrl));
            check(wait_o == e.wt, "R9", int'(wait_o), int'(e.wt));
        end
    end

    // driver: applies one cycle of conditions and pushes the expected outcome
    task automatic run_cycle(logic [NEXT-1:0] ext, logic [NFLAG-1:0] flags);
        exp_t e;
        logic c;
        logic tk;
        @(negedge clk);
        ext_cond_i  = ext;
        alu_flags_i = flags;
        #2;
        c = cond_of(m_word.csel, m_flq, ext);
        unique case (m_word.mode)
            M_CONT: begin tk = 1'b0; e.tag = "R2"; end
            M_JUMP: begin tk = 1'b1; e.tag = "R3"; end
            M_JT:   begin tk = c;    e.tag = "R4"; end
            M_JF:   begin tk = !c;   e.tag = "R5"; end
        endcase
        if (m_word.mode == M_JT || m_word.mode == M_JF) begin
            if (m_word.csel == 0) e.tag = "R6";
            else if (m_word.csel <= NFLAG) e.tag = "R7";
        end
        e.addr = tk ? m_word.target : AW'(m_pc + 1'b1);
        e.ctrl = m_word.ctrl;
        e.wt   = tk && (m_word.target == m_pc);
        if (e.wt) e.tag = "R9";
        q.push_back(e);
        @(posedge clk);
        #1;
        m_pc   = e.addr;
        m_word = rom[e.addr];
        m_flq  = flags;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ext_cond_i  = '0;
        alu_flags_i = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #2;
            check(uaddr_o == '0, "R1", int'(uaddr_o), 0);
            check(ctrl_o == '0, "R1", int'(ctrl_o), 0);
            check(wait_o == 1'b0, "R1", int'(wait_o), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        #2;
        check(uaddr_o == '0, "R1", int'(uaddr_o), 0);
        @(posedge clk);
        #1;
        m_pc   = '0;
        m_word = rom[0];
        m_flq  = '0;
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < 2**AW; i++) rom[i] = mk(i ^ 8'h5A, M_CONT, 0, 0);
        rom[1]  = mk(8'h11, M_JF,   5,  1);   // wait for external line 0
        rom[3]  = mk(8'h33, M_JT,   1,  8);   // flag 0
        rom[4]  = mk(8'h44, M_JF,   2,  9);   // flag 1
        rom[5]  = mk(8'h55, M_JUMP, 7, 62);
        rom[8]  = mk(8'h88, M_JT,   0, 12);   // always taken
        rom[9]  = mk(8'h99, M_JF,   0, 40);   // never taken
        rom[10] = mk(8'hA0, M_JT,  15,  3);   // external line 10
        rom[11] = mk(8'hB0, M_JUMP, 0,  3);
        rom[12] = mk(8'hC0, M_JF,   6,  3);   // external line 1
        rom[13] = mk(8'hD0, M_JUMP, 3, 62);
        rom[14] = mk(8'hE0, M_JT,   3, 14);   // self loop on flag 2

        do_reset();
        // all conditions low: word 1 waits
        for (int i = 0; i < 20; i++) run_cycle('0, '0);
        // all conditions high
        for (int i = 0; i < 30; i++) run_cycle('1, '1);
        // random patterns
        for (int i = 0; i < 400; i++)
            run_cycle(NEXT'($urandom), NFLAG'($urandom));
        do_reset();
        for (int i = 0; i < 300; i++)
            run_cycle(NEXT'($urandom), NFLAG'($urandom));
        // direct path through the wrap at address 63
        for (int i = 0; i < 12; i++) run_cycle(11'h001, 4'b0010);
        @(negedge clk);
        #6;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule